// File: doc/BRIEF.md
# Card Interface Power-Down and Session-Start Gate

This block sits between a host controller and the analog front end of a card interface. It decides when the analog and oscillator domain may be switched off, how long the block waits after wake-up before that domain can be trusted, and whether a host request to open a card session is honoured. A downstream activation sequencer receives a single session-activate level from it.

The host requests low power with an active-high power-down input. The request takes effect only when no session is open. Releasing it starts a recovery window of a fixed number of clock cycles. During that window, and while powered down, a start request is thrown away. A session opens only on a fresh low-to-high edge of the start/stop bit seen after recovery. Card presence is watched in every state and raises an interrupt level, which the host clears with a one-cycle pulse. A fault on either supply forces the session off in the same cycle. The asynchronous reset, driven by the logic-supply supervisor, holds the block powered down.

Top module: `card_pwr_gate`

## Requirements
- R1: While reset is asserted, and directly after it, irq_o, analog_en_o and sess_act_o are all 0.
- R2: When power-down is requested with start_i at 0 and no session open, analog_en_o goes to 0 and stays 0 while the request is held.
- R3: A power-down request made while a session is open is ignored: analog_en_o and sess_act_o both stay 1.
- R4: A rising edge of card_det_i while powered down sets irq_o to 1.
- R5: After power-down is released, analog_en_o returns to 1 and a recovery window of RECOV_CYCLES clock cycles runs before start requests can be accepted.
- R6: A rise of start_i while powered down or during recovery is discarded. A level still high when recovery ends opens no session. A new low-then-high toggle is needed.
- R7: Outside recovery and power-down, a rising edge of start_i opens a session: sess_act_o goes to 1 on the third clock edge after the change. Driving start_i to 0 closes the session.
- R8: With a card present, irq_o goes to 1 on the clock edge that ends recovery, RECOV_CYCLES+3 edges after power-down is released, and not before.
- R9: A fault on vdd_fault_i or vcc_fault_i drops sess_act_o in the same cycle. The session stays closed, even with start_i held at 1, until start_i returns to 0 and rises again.
- R10: irq_o is a level that stays set until a pulse on irq_clr_i clears it. A further presence edge while it is set keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset from the supply supervisor |
| pd_req_i | input | 1 | Active-high power-down request |
| start_i | input | 1 | Host start/stop control bit |
| card_det_i | input | 1 | Card presence detect, 1 = present |
| vdd_fault_i | input | 1 | Logic supply fault flag |
| vcc_fault_i | input | 1 | Card supply fault flag |
| irq_clr_i | input | 1 | Write-one-to-clear pulse for the interrupt |
| irq_o | output | 1 | Interrupt level to the host |
| analog_en_o | output | 1 | Enable for the analog and oscillator domain |
| sess_act_o | output | 1 | Session-activate request to the activation sequencer |

## Verification
The start bit is tried in four patterns. It is raised during power-down, raised during recovery, held high across the end of recovery, and toggled cleanly afterwards. These patterns separate edge-based acceptance from level-based acceptance and show whether the recovery gate holds. Power-down requests come both inside and outside a session, which shows whether the session interlock works. Fault pulses arrive with start held high, then start is released and raised again, so re-arming is tested. A random mix of toggles, faults and power-down pulses during sessions is compared against a small bench model of the expected session level.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [2:0] {
    PG_OFF    = 3'd0,
    PG_RECOV  = 3'd1,
    PG_IDLE   = 3'd2,
    PG_ACTIVE = 3'd3,
    PG_FAULT  = 3'd4
  } pg_state_e;
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain[s] <= '0;
      end else begin
        if (s == 0) chain[s] <= d_i;
        else        chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pg_recov_timer.sv
module pg_recov_timer #(
  parameter int CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done_o = run_i && (cnt_q == LAST);
  assign cnt_en = !run_i || !done_o;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pg_fsm.sv
module pg_fsm
  import pg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pd_i,
  input  logic      start_lvl_i,
  input  logic      start_rise_i,
  input  logic      fault_i,
  input  logic      recov_done_i,
  output pg_state_e state_o
);
  pg_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PG_OFF:    if (!pd_i) st_d = PG_RECOV;
      PG_RECOV: begin
        if (pd_i)              st_d = PG_OFF;
        else if (recov_done_i) st_d = PG_IDLE;
      end
      PG_IDLE: begin
        if (pd_i && !start_lvl_i)          st_d = PG_OFF;
        else if (start_rise_i && !fault_i) st_d = PG_ACTIVE;
      end
      PG_ACTIVE: begin
        if (fault_i)           st_d = PG_FAULT;
        else if (!start_lvl_i) st_d = PG_IDLE;
      end
      PG_FAULT:  if (!start_lvl_i && !fault_i) st_d = PG_IDLE;
      default:   st_d = PG_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PG_OFF;
    else        st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/card_pwr_gate.sv
module card_pwr_gate
  import pg_pkg::*;
#(
  parameter int RECOV_CYCLES = 1000000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req_i,
  input  logic start_i,
  input  logic card_det_i,
  input  logic vdd_fault_i,
  input  logic vcc_fault_i,
  input  logic irq_clr_i,
  output logic irq_o,
  output logic analog_en_o,
  output logic sess_act_o
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0] raw_in, syn_out;
  logic pd_s, start_s, det_s;
  logic start_q, det_q;
  logic start_rise, det_rise;
  logic fault_any, recov_done, recov_end_irq;
  logic irq_q, irq_d, irq_en;
  pg_state_e state;

  assign raw_in = {pd_req_i, start_i, card_det_i};

  pg_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn_out)
  );

  assign pd_s    = syn_out[2];
  assign start_s = syn_out[1];
  assign det_s   = syn_out[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      det_q   <= 1'b0;
    end else begin
      start_q <= start_s;
      det_q   <= det_s;
    end
  end

  assign start_rise = start_s && !start_q;
  assign det_rise   = det_s && !det_q;
  assign fault_any  = vdd_fault_i || vcc_fault_i;

  pg_recov_timer #(.CYCLES(RECOV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(state == PG_RECOV), .done_o(recov_done)
  );

  pg_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pd_i(pd_s), .start_lvl_i(start_s),
    .start_rise_i(start_rise), .fault_i(fault_any),
    .recov_done_i(recov_done), .state_o(state)
  );

  assign recov_end_irq = recov_done && det_s && !pd_s;

  always_comb begin
    irq_en = det_rise || recov_end_irq || irq_clr_i;
    irq_d  = det_rise || recov_end_irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_d;
  end

  assign irq_o       = irq_q;
  assign analog_en_o = (state != PG_OFF) && rst_n;
  assign sess_act_o  = (state == PG_ACTIVE) && !fault_any;
endmodule

// File: rtl/pg_checker.sv
module pg_checker (
  input logic clk,
  input logic rst_n,
  input logic fault,
  input logic start_s,
  input logic start_q,
  input logic irq_clr,
  input logic irq,
  input logic analog_en,
  input logic sess_act
);
  // R9: a supply fault closes the session in the same cycle
  assert_fault_kills_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !sess_act);

  // R3: power is never removed from an open session
  assert_no_pd_in_session_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(analog_en) |-> !$past(sess_act));

  // R2: a session never exists without the analog domain
  assert_sess_needs_power_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sess_act |-> analog_en);

  // R7: a session opens only after a synchronized rising edge of start
  assert_sess_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sess_act) |-> ($past(start_s) && !$past(start_q)));

  // R10: interrupt holds until cleared
  assert_irq_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
endmodule

bind card_pwr_gate pg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .fault(vdd_fault_i || vcc_fault_i),
  .start_s(start_s), .start_q(start_q), .irq_clr(irq_clr_i),
  .irq(irq_o), .analog_en(analog_en_o), .sess_act(sess_act_o)
);

// File: tb/card_pwr_gate_tb.sv
module card_pwr_gate_tb;
  localparam int N = 300;

  logic clk, rst_n, pd_req, start, det, vddf, vccf, clr;
  logic irq, aen, sess;
  int n_run, n_fail;
  bit done;

  card_pwr_gate #(.RECOV_CYCLES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .pd_req_i(pd_req), .start_i(start),
    .card_det_i(det), .vdd_fault_i(vddf), .vcc_fault_i(vccf),
    .irq_clr_i(clr), .irq_o(irq), .analog_en_o(aen), .sess_act_o(sess)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic drv_start(input logic v);
    @(negedge clk); start = v;
  endtask

  function automatic logic exp_after_toggle(input logic cur_start);
    return !cur_start;
  endfunction

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    rst_n = 0; pd_req = 1; start = 0; det = 0; vddf = 0; vccf = 0; clr = 0;
    cyc(3);
    chk("R1 irq", irq, 0); chk("R1 aen", aen, 0); chk("R1 sess", sess, 0);
    @(negedge clk); rst_n = 1;
    cyc(6);
    chk("R1 sess after", sess, 0);
    chk("R2 aen in pd", aen, 0);
    // R4: insertion in power-down
    @(negedge clk); det = 1; cyc(5);
    chk("R4 irq", irq, 1);
    // R10: clear
    @(negedge clk); clr = 1; @(negedge clk); clr = 0; cyc(3);
    chk("R10 cleared", irq, 0);
    @(negedge clk); det = 0; cyc(4); @(negedge clk); det = 1; cyc(5);
    chk("R10 set again", irq, 1);
    @(negedge clk); det = 0; cyc(4); @(negedge clk); det = 1; cyc(5);
    chk("R10 stays set", irq, 1);
    @(negedge clk); clr = 1; @(negedge clk); clr = 0; cyc(3);
    // R6: start raised while powered down
    drv_start(1); cyc(5);
    chk("R6 no sess in pd", sess, 0);
    // R5/R8: release power-down, exact end of recovery
    @(negedge clk); pd_req = 0;
    cyc(5);
    chk("R5 aen in recovery", aen, 1);
    chk("R8 irq not yet", irq, 0);
    cyc(N - 3);
    chk("R8 irq before end", irq, 0);
    cyc(1);
    chk("R8 irq at end", irq, 1);
    cyc(5);
    chk("R6 level held ignored", sess, 0);
    drv_start(0); cyc(5);
    // R7: exact latency
    drv_start(1);
    cyc(2); chk("R7 not yet", sess, 0);
    cyc(1); chk("R7 opened", sess, 1);
    // R3: power-down during session ignored
    @(negedge clk); pd_req = 1; cyc(10);
    chk("R3 aen held", aen, 1); chk("R3 sess held", sess, 1);
    @(negedge clk); pd_req = 0; cyc(3);
    // R9: fault immediate
    @(negedge clk); vccf = 1; #1;
    chk("R9 immediate", sess, 0);
    @(negedge clk); vccf = 0; cyc(6);
    chk("R9 stays closed", sess, 0);
    drv_start(0); cyc(5); chk("R9 after low", sess, 0);
    drv_start(1); cyc(5); chk("R9 re-armed", sess, 1);
    @(negedge clk); vddf = 1; #1; chk("R9 vdd fault", sess, 0);
    @(negedge clk); vddf = 0;
    drv_start(0); cyc(5);
    // R2 + R6: power down from idle, start raised in recovery
    @(negedge clk); pd_req = 1; cyc(5);
    chk("R2 aen off", aen, 0);
    @(negedge clk); pd_req = 0; cyc(20);
    drv_start(1); cyc(N);
    chk("R6 recovery edge dropped", sess, 0);
    chk("R5 aen back", aen, 1);
    drv_start(0); cyc(5); drv_start(1); cyc(5);
    chk("R7 after toggle", sess, 1);
    // random phase
    begin
      logic exp_act;
      int op;
      void'($urandom(1234));
      exp_act = 1;
      for (int k = 0; k < 80; k++) begin
        op = $urandom_range(0, 2);
        if (op == 0) begin
          if (start) exp_act = 0;
          else       exp_act = exp_after_toggle(start);
          drv_start(!start);
        end else if (op == 1) begin
          @(negedge clk);
          if ($urandom_range(0, 1) != 0) vccf = 1; else vddf = 1;
          @(negedge clk); vccf = 0; vddf = 0;
          exp_act = 0;
        end else if (start) begin
          @(negedge clk); pd_req = 1; cyc(4); @(negedge clk); pd_req = 0;
        end
        cyc(6);
        chk("R7/R9 random sess", sess, exp_act);
        chk("R3 random aen", aen, 1);
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule